// File: doc/BRIEF.md
# Pipelined Ternary Match Table

This block holds a table of DEPTH ternary entries. Each entry has a match value, a care mask, a valid bit and a result word. A search key goes in with a strobe. A fixed number of cycles later the block returns a hit flag and the result word of the matching entry that has the lowest index. A care-mask bit of 0 makes that key bit a don't-care. A care-mask bit of 1 requires the key bit to equal the stored bit.

The table is split into ROWS rows. Each row is a chain of UNITS compare units. Each unit holds DEPTH/(ROWS·UNITS) entries and checks them over STAGES pipeline stages. The rows search at the same time. The key walks down each row, and the best match found so far travels with it. A cross-row encoder stage picks the winner. An output stage then fetches the result word and registers it. The total latency is UNITS·STAGES+2 cycles, and a new key may enter on every cycle. Entries are loaded through a single write port, one entry per cycle.

Top module: `tcam_lookup`

## Requirements
- R1: A key bit whose care-mask bit is 0 matches whatever the stored bit is. A key bit whose care-mask bit is 1 matches only if it equals the stored bit.
- R2: `res_vld` goes high exactly UNITS·STAGES+2 clock cycles after the cycle in which `key_vld` was sampled high. With the default parameters this is 6 cycles.
- R3: When several valid entries match, the lowest entry index wins. `res_hit` is 1 and `res_data` carries that entry's result word.
- R4: When no valid entry matches, `res_vld` is 1, `res_hit` is 0 and `res_data` is 0.
- R5: Keys may be presented on consecutive cycles. Results come out one per cycle, in the order the keys went in.
- R6: When `res_vld` is 0, `res_hit` and `res_data` are 0.
- R7: An entry written at index `wr_idx` while `wr_en` is high is used by every key presented on any later cycle.
- R8: An entry written with `wr_keep` = 0 never matches, whatever its value and mask.
- R9: A synchronous reset marks every entry invalid and clears the outputs. After reset every key misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one entry this cycle |
| wr_idx | input | $clog2(DEPTH) | Index of the entry to write; a lower index has higher priority |
| wr_keep | input | 1 | Valid bit stored with the entry |
| wr_value | input | KEY_W | Match value stored with the entry |
| wr_care | input | KEY_W | Care mask; bit = 1 means the key bit must equal the stored bit |
| wr_result | input | RES_W | Result word stored with the entry |
| key_vld | input | 1 | A key is presented this cycle |
| key | input | KEY_W | Search key |
| res_vld | output | 1 | Registered result valid |
| res_hit | output | 1 | At least one valid entry matched |
| res_data | output | RES_W | Result word of the winning entry, 0 on a miss |

## Verification
The directed keys are chosen so that several entries overlap. An exact entry, a nibble-masked entry and an all-don't-care entry cover the same keys, and only the correct lowest-index choice gives the expected result word. An invalid entry whose value equals the key shows that valid bits are honoured. Invalidating or adding an entry, then sending a key on the very next cycle, separates the correct write timing from stale reads. A long stream of mostly back-to-back random keys with random gaps is compared cycle by cycle against a queue-based model. That stream exposes latency slips, reordering and lost results, and a reset taken mid-stream shows that the table is cleared.

// File: rtl/tcam_pkg.sv
package tcam_pkg;

    localparam int unsigned TC_IDX_W   = 16;
    localparam int unsigned TC_KEY_MAX = 64;

    typedef struct packed {
        logic                hit;
        logic [TC_IDX_W-1:0] idx;
    } tc_hit_t;

    localparam tc_hit_t TC_NONE = '0;

    // Ternary compare: masked-out bits never cause a mismatch.
    function automatic logic tc_match(
        input logic [TC_KEY_MAX-1:0] k,
        input logic [TC_KEY_MAX-1:0] v,
        input logic [TC_KEY_MAX-1:0] c
    );
        return ((k ^ v) & c) == '0;
    endfunction

endpackage

// File: rtl/tcam_unit.sv
module tcam_unit
    import tcam_pkg::*;
#(
    parameter int unsigned KEY_W  = 8,
    parameter int unsigned EPU    = 4,
    parameter int unsigned STAGES = 2,
    parameter int unsigned BASE   = 0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_vld,
    input  tc_hit_t                 in_hit,
    input  logic [STAGES*KEY_W-1:0] stage_keys,
    input  logic [EPU*KEY_W-1:0]    ent_val,
    input  logic [EPU*KEY_W-1:0]    ent_care,
    input  logic [EPU-1:0]          ent_ok,
    output logic                    out_vld,
    output tc_hit_t                 out_hit
);

    localparam int unsigned CH = EPU / STAGES;

    logic [STAGES:0] stg_vld;
    tc_hit_t         stg_hit [STAGES+1];

    assign stg_vld[0] = in_vld;
    assign stg_hit[0] = in_hit;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        tc_hit_t                 nxt;
        logic    [KEY_W-1:0]     skey;
        assign skey = stage_keys[s*KEY_W +: KEY_W];

        always_comb begin
            nxt = stg_hit[s];
            if (!stg_hit[s].hit) begin
                for (int j = CH - 1; j >= 0; j--) begin
                    if (ent_ok[s*CH + j] &&
                        tc_match(TC_KEY_MAX'(skey),
                                 TC_KEY_MAX'(ent_val[(s*CH + j)*KEY_W +: KEY_W]),
                                 TC_KEY_MAX'(ent_care[(s*CH + j)*KEY_W +: KEY_W]))) begin
                        nxt.hit = 1'b1;
                        nxt.idx = TC_IDX_W'(BASE + s*CH + j);
                    end
                end
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                stg_vld[s+1] <= 1'b0;
                stg_hit[s+1] <= TC_NONE;
            end else begin
                stg_vld[s+1] <= stg_vld[s];
                stg_hit[s+1] <= stg_vld[s] ? nxt : TC_NONE;
            end
        end
    end

    assign out_vld = stg_vld[STAGES];
    assign out_hit = stg_hit[STAGES];

    // R3: a winner leaving this unit is never above this unit's index range
    a_r3_idx_range: assert property (@(posedge clk) disable iff (rst)
        out_hit.hit |-> (out_hit.idx < TC_IDX_W'(BASE + EPU)));

    // R6: no hit travels without a key
    a_r6_unit_quiet: assert property (@(posedge clk) disable iff (rst)
        !out_vld |-> !out_hit.hit);

endmodule

// File: rtl/tcam_row.sv
module tcam_row
    import tcam_pkg::*;
#(
    parameter int unsigned KEY_W  = 8,
    parameter int unsigned UNITS  = 2,
    parameter int unsigned STAGES = 2,
    parameter int unsigned EPU    = 4,
    parameter int unsigned ROW    = 0
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         in_vld,
    input  logic [KEY_W-1:0]             in_key,
    input  logic [UNITS*EPU*KEY_W-1:0]   ent_val,
    input  logic [UNITS*EPU*KEY_W-1:0]   ent_care,
    input  logic [UNITS*EPU-1:0]         ent_ok,
    output logic                         out_vld,
    output tc_hit_t                      out_hit
);

    localparam int unsigned LH = UNITS * STAGES;

    // key delay line: slot k holds the key k cycles after entry
    logic [LH*KEY_W-1:0] kline;
    assign kline[KEY_W-1:0] = in_key;

    if (LH > 1) begin : g_kline
        always_ff @(posedge clk) begin
            kline[LH*KEY_W-1:KEY_W] <= kline[(LH-1)*KEY_W-1:0];
        end
    end

    logic [UNITS:0] c_vld;
    tc_hit_t        c_hit [UNITS+1];

    assign c_vld[0] = in_vld;
    assign c_hit[0] = TC_NONE;

    for (genvar u = 0; u < UNITS; u++) begin : g_unit
        tcam_unit #(
            .KEY_W (KEY_W),
            .EPU   (EPU),
            .STAGES(STAGES),
            .BASE  ((ROW*UNITS + u) * EPU)
        ) u_unit (
            .clk       (clk),
            .rst       (rst),
            .in_vld    (c_vld[u]),
            .in_hit    (c_hit[u]),
            .stage_keys(kline[u*STAGES*KEY_W +: STAGES*KEY_W]),
            .ent_val   (ent_val[u*EPU*KEY_W +: EPU*KEY_W]),
            .ent_care  (ent_care[u*EPU*KEY_W +: EPU*KEY_W]),
            .ent_ok    (ent_ok[u*EPU +: EPU]),
            .out_vld   (c_vld[u+1]),
            .out_hit   (c_hit[u+1])
        );
    end

    assign out_vld = c_vld[UNITS];
    assign out_hit = c_hit[UNITS];

endmodule

// File: rtl/tcam_lookup.sv
module tcam_lookup
    import tcam_pkg::*;
#(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned KEY_W  = 8,
    parameter int unsigned RES_W  = 8,
    parameter int unsigned ROWS   = 2,
    parameter int unsigned UNITS  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_idx,
    input  logic                     wr_keep,
    input  logic [KEY_W-1:0]         wr_value,
    input  logic [KEY_W-1:0]         wr_care,
    input  logic [RES_W-1:0]         wr_result,
    input  logic                     key_vld,
    input  logic [KEY_W-1:0]         key,
    output logic                     res_vld,
    output logic                     res_hit,
    output logic [RES_W-1:0]         res_data
);

    localparam int unsigned AW   = $clog2(DEPTH);
    localparam int unsigned EPU  = DEPTH / (ROWS * UNITS);
    localparam int unsigned RSPAN = UNITS * EPU;

    // entry storage
    logic [DEPTH*KEY_W-1:0] val_mem;
    logic [DEPTH*KEY_W-1:0] care_mem;
    logic [DEPTH-1:0]       ok_mem;
    logic [RES_W-1:0]       res_mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            ok_mem <= '0;
        end else if (wr_en) begin
            ok_mem[wr_idx] <= wr_keep;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            val_mem[wr_idx*KEY_W +: KEY_W]  <= wr_value;
            care_mem[wr_idx*KEY_W +: KEY_W] <= wr_care;
            res_mem[wr_idx]                 <= wr_result;
        end
    end

    // parallel rows
    logic [ROWS-1:0] row_vld;
    tc_hit_t         row_hit [ROWS];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        tcam_row #(
            .KEY_W (KEY_W),
            .UNITS (UNITS),
            .STAGES(STAGES),
            .EPU   (EPU),
            .ROW   (r)
        ) u_row (
            .clk     (clk),
            .rst     (rst),
            .in_vld  (key_vld),
            .in_key  (key),
            .ent_val (val_mem[r*RSPAN*KEY_W +: RSPAN*KEY_W]),
            .ent_care(care_mem[r*RSPAN*KEY_W +: RSPAN*KEY_W]),
            .ent_ok  (ok_mem[r*RSPAN +: RSPAN]),
            .out_vld (row_vld[r]),
            .out_hit (row_hit[r])
        );
    end

    // cross-row priority encode: lower row holds lower indices
    tc_hit_t pick;
    always_comb begin
        pick = TC_NONE;
        for (int r = ROWS - 1; r >= 0; r--) begin
            if (row_hit[r].hit) pick = row_hit[r];
        end
    end

    logic                enc_vld;
    logic                enc_hit;
    logic [TC_IDX_W-1:0] enc_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            enc_vld <= 1'b0;
            enc_hit <= 1'b0;
            enc_idx <= '0;
        end else begin
            enc_vld <= row_vld[0];
            enc_hit <= row_vld[0] & pick.hit;
            enc_idx <= pick.idx;
        end
    end

    // registered output
    always_ff @(posedge clk) begin
        if (rst) begin
            res_vld  <= 1'b0;
            res_hit  <= 1'b0;
            res_data <= '0;
        end else begin
            res_vld  <= enc_vld;
            res_hit  <= enc_vld & enc_hit;
            res_data <= (enc_vld && enc_hit) ? res_mem[enc_idx[AW-1:0]] : '0;
        end
    end

    // R2: all rows finish the same key on the same cycle
    a_r2_rows_aligned: assert property (@(posedge clk) disable iff (rst)
        (row_vld == '0) || (&row_vld));

    // R3: the encoded winner is a real table index
    a_r3_idx_in_depth: assert property (@(posedge clk) disable iff (rst)
        enc_hit |-> (enc_idx < TC_IDX_W'(DEPTH)));

    // R4: a miss carries a zero result word
    a_r4_miss_zero: assert property (@(posedge clk) disable iff (rst)
        (res_vld && !res_hit) |-> (res_data == '0));

    // R6: outputs are quiet between results
    a_r6_quiet: assert property (@(posedge clk) disable iff (rst)
        !res_vld |-> (!res_hit && res_data == '0));

endmodule

// File: tb/tcam_lookup_bench.sv
module tcam_lookup_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH  = 16;
    localparam int KEY_W  = 8;
    localparam int RES_W  = 8;
    localparam int ROWS   = 2;
    localparam int UNITS  = 2;
    localparam int STAGES = 2;
    localparam int LAT    = UNITS * STAGES + 2;
    localparam int AW     = $clog2(DEPTH);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic [AW-1:0]    wr_idx = '0;
    logic             wr_keep = 1'b0;
    logic [KEY_W-1:0] wr_value = '0;
    logic [KEY_W-1:0] wr_care = '0;
    logic [RES_W-1:0] wr_result = '0;
    logic             key_vld = 1'b0;
    logic [KEY_W-1:0] key = '0;
    logic             res_vld;
    logic             res_hit;
    logic [RES_W-1:0] res_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    tcam_lookup #(
        .DEPTH(DEPTH), .KEY_W(KEY_W), .RES_W(RES_W),
        .ROWS(ROWS), .UNITS(UNITS), .STAGES(STAGES)
    ) u_tcam_lookup (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_keep(wr_keep),
        .wr_value(wr_value), .wr_care(wr_care), .wr_result(wr_result),
        .key_vld(key_vld), .key(key),
        .res_vld(res_vld), .res_hit(res_hit), .res_data(res_data)
    );

    // reference table
    bit               m_ok  [DEPTH];
    logic [KEY_W-1:0] m_val [DEPTH];
    logic [KEY_W-1:0] m_care[DEPTH];
    logic [RES_W-1:0] m_res [DEPTH];

    // expected-result delay queue
    bit               hv [LAT];
    bit               hh [LAT];
    logic [RES_W-1:0] hr [LAT];
    string            ht [LAT];

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    task automatic check3(input string tag, input bit ev, input bit eh,
                          input logic [RES_W-1:0] er);
        n_checks++;
        if (res_vld !== ev || res_hit !== eh || res_data !== er) begin
            n_fail++;
            $display("FAIL %s: got vld=%b hit=%b data=%h, expected vld=%b hit=%b data=%h",
                     tag, res_vld, res_hit, res_data, ev, eh, er);
        end
    endtask

    task automatic clear_hist();
        for (int i = 0; i < LAT; i++) begin
            hv[i] = 1'b0; hh[i] = 1'b0; hr[i] = '0; ht[i] = "R6 idle";
        end
    endtask

    // one clock of stimulus; checks the result due on this cycle
    task automatic cyc(input bit kv, input logic [KEY_W-1:0] k,
                       input bit we, input int wi, input bit wk,
                       input logic [KEY_W-1:0] wv, input logic [KEY_W-1:0] wc,
                       input logic [RES_W-1:0] wr, input string tag);
        bit               eh;
        logic [RES_W-1:0] er;
        @(negedge clk);
        check3(ht[LAT-1], hv[LAT-1], hh[LAT-1], hr[LAT-1]);
        for (int i = LAT - 1; i > 0; i--) begin
            hv[i] = hv[i-1]; hh[i] = hh[i-1]; hr[i] = hr[i-1]; ht[i] = ht[i-1];
        end
        eh = 1'b0;
        er = '0;
        if (kv) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (!eh && m_ok[i] && (((k ^ m_val[i]) & m_care[i]) == '0)) begin
                    eh = 1'b1;
                    er = m_res[i];
                end
            end
        end
        hv[0] = kv;
        hh[0] = eh;
        hr[0] = er;
        ht[0] = kv ? tag : "R6 idle";
        key_vld   = kv;
        key       = k;
        wr_en     = we;
        wr_idx    = AW'(wi);
        wr_keep   = wk;
        wr_value  = wv;
        wr_care   = wc;
        wr_result = wr;
        if (we) begin
            m_ok[wi] = wk; m_val[wi] = wv; m_care[wi] = wc; m_res[wi] = wr;
        end
    endtask

    task automatic look(input logic [KEY_W-1:0] k, input string tag);
        cyc(1'b1, k, 1'b0, 0, 1'b0, '0, '0, '0, tag);
    endtask

    task automatic put(input int wi, input bit wk, input logic [KEY_W-1:0] wv,
                       input logic [KEY_W-1:0] wc, input logic [RES_W-1:0] wr);
        cyc(1'b0, '0, 1'b1, wi, wk, wv, wc, wr, "R6 idle");
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, '0, 1'b0, 0, 1'b0, '0, '0, '0, "R6 idle");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; key_vld = 1'b0; wr_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check3("R9 reset outputs", 1'b0, 1'b0, '0);
        for (int i = 0; i < DEPTH; i++) m_ok[i] = 1'b0;
        clear_hist();
        rst = 1'b0;
    endtask

    initial begin
        clear_hist();
        for (int i = 0; i < DEPTH; i++) begin
            m_ok[i] = 1'b0; m_val[i] = '0; m_care[i] = '0; m_res[i] = '0;
        end
        do_reset();

        // R9: after reset the empty table misses
        look(8'hA5, "R9 R4 empty table");
        idle(LAT);

        put(3,  1'b1, 8'hA5, 8'hFF, 8'h11);   // exact
        put(5,  1'b1, 8'hA0, 8'hF0, 8'h22);   // high nibble A, R1
        put(12, 1'b1, 8'h00, 8'h00, 8'h33);   // all don't-care, R1
        put(9,  1'b0, 8'h5A, 8'hFF, 8'h44);   // invalid, R8
        put(14, 1'b1, 8'h5A, 8'hFF, 8'h55);
        put(1,  1'b1, 8'h0F, 8'h0F, 8'h66);   // low nibble F, R1
        idle(2);

        // back-to-back keys, overlapping entries
        look(8'hA5, "R2 R5 R3 exact beats wider");
        look(8'hAF, "R2 R5 R1 R3 masked idx1");
        look(8'hA3, "R2 R5 R1 nibble entry");
        look(8'h5A, "R2 R5 R8 invalid skipped");
        look(8'h12, "R2 R5 R1 dont-care catch");
        idle(1);
        look(8'h3F, "R2 R1 R3 low nibble");
        idle(LAT);

        // R7 R8: invalidate then search on the next cycle
        put(12, 1'b0, 8'h00, 8'h00, 8'h33);
        look(8'h5A, "R7 R8 invalidated entry");
        look(8'h77, "R4 miss zero result");
        put(0,  1'b1, 8'h00, 8'h00, 8'h77);
        look(8'hA5, "R7 R3 new idx0 wins");
        idle(LAT);

        // random stream, mostly back to back
        put(0,  1'b0, 8'h00, 8'h00, 8'h00);
        put(7,  1'b1, 8'h30, 8'hF0, 8'h88);
        put(11, 1'b1, 8'h81, 8'h81, 8'h99);
        for (int n = 0; n < 400; n++) begin
            logic [KEY_W-1:0] rk;
            rk = KEY_W'($urandom);
            if (($urandom % 5) == 0)
                idle(1);
            else
                look(rk, "R5 R2 R3 R4 random stream");
        end
        idle(2);

        // mid-stream reset clears the table
        look(8'hA5, "R5 in flight");
        look(8'h5A, "R5 in flight");
        do_reset();
        look(8'hA5, "R9 cleared table");
        look(8'h3F, "R9 cleared table");
        idle(LAT + 1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule